// File: doc/BRIEF.md
# Decryptor Control and Error Status Registers

This block is the global control and status slice of an on-the-fly flash decryption engine. It sits on an APB-style register bus and holds four configuration controls: engine enable, key-unwrap enable, key-loaded flag and interrupt enable. These controls are also driven out as level signals so the engine can use them.

A separate key-unwrap engine reports into the block with single-cycle done and error pulses. The error pulse comes with a 4-bit context mask. The block keeps a sticky error flag and a per-context error field. Software can raise the flag through a force-error test write and can clear it with a clear command. One interrupt line goes high while an error is pending and interrupts are enabled.

Top module: `fdec_ctrl_regs`

## Requirements
- R1: After reset, every configuration and status bit is 0, a read of either register returns 0, and `irq` is low.
- R2: The configuration register sits at offset 0xC00. It stores engine enable (bit 31), key-loaded (bit 30), unwrap enable (bit 5) and interrupt enable (bit 0). Every other bit reads 0.
- R3: The status register sits at offset 0xC04. Bit 29 mirrors engine enable and bit 30 mirrors unwrap enable.
- R4: An `unwrap_err_pulse` sets the error flag (status bit 0) and ORs `unwrap_ctx` into the context field (status bits 19:16, bit 16 = context 0). Bits already set in the field stay set.
- R5: A configuration write with bit 1 set (force error) sets the error flag and clears the context field to zero. Bit 1 always reads 0.
- R6: A configuration write with bit 2 set clears the error flag, and the context field clears with it. Bit 2 always reads 0.
- R7: `irq` is high exactly when the error flag is set and interrupt enable is 1.
- R8: Status bit 31 (unwrap done) is set by `unwrap_done_pulse` only while unwrap enable is 1. A configuration write with bit 5 equal to 0 clears it. It reads 0 whenever unwrap enable is 0.
- R9: Writes to the status register are ignored. Reads of any other offset return 0.
- R10: If an error pulse arrives in the same cycle as a clear or force write, the detection wins. The flag stays set and the context field becomes its old value ORed with the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when 1 |
| paddr | input | 12 | Bus byte address |
| pwdata | input | 32 | Bus write data |
| prdata | output | 32 | Bus read data, valid while selected for a read |
| unwrap_done_pulse | input | 1 | Key unwrap finished |
| unwrap_err_pulse | input | 1 | Key unwrap error detected |
| unwrap_ctx | input | 4 | Contexts reporting the error |
| engine_en | output | 1 | Engine enable control |
| unwrap_en | output | 1 | Key-unwrap enable control |
| key_loaded | output | 1 | Key-loaded flag |
| irq | output | 1 | Error interrupt request |

## Verification
Some rules are checked every cycle by the bound assertions:
- Detection sets the flag and keeps every reported context bit.
- A force write without a detection in the same cycle leaves the flag set and the context field empty.
- The context field is never non-zero while the flag is clear.
- No interrupt is raised while interrupts are disabled.
- Unwrap done never reads as 1 while unwrap is disabled.

Other behaviour needs the bench's scenarios: register readback values, ignored status writes, accumulation across several pulses, the same-cycle priority of detection over clear, and done pulses dropped while unwrap is disabled.

// File: rtl/fdec_ctrl_regs.sv
module fdec_ctrl_regs #(
  parameter int ADDR_W = 12,
  parameter int NCTX = 4,
  parameter logic [ADDR_W-1:0] CFG_OFS = 12'hC00,
  parameter logic [ADDR_W-1:0] STA_OFS = 12'hC04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              unwrap_done_pulse,
  input  logic              unwrap_err_pulse,
  input  logic [NCTX-1:0]   unwrap_ctx,
  output logic              engine_en,
  output logic              unwrap_en,
  output logic              key_loaded,
  output logic              irq
);
  localparam int CTX_LO = 16;

  logic cfg_en, cfg_kl, cfg_uw, cfg_ie;
  logic err_flag, done_seen;
  logic [NCTX-1:0] err_ctx;
  logic [31:0] cfg_word, sta_word;

  wire bus_wr   = psel & penable & pwrite;
  wire cfg_wr   = bus_wr && (paddr == CFG_OFS);
  wire force_wr = cfg_wr & pwdata[1];
  wire clear_wr = cfg_wr & pwdata[2];
  logic unused_bits;
  assign unused_bits = ^{pwdata[29:6], pwdata[4:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en <= 1'b0;
      cfg_kl <= 1'b0;
      cfg_uw <= 1'b0;
      cfg_ie <= 1'b0;
    end else if (cfg_wr) begin
      cfg_en <= pwdata[31];
      cfg_kl <= pwdata[30];
      cfg_uw <= pwdata[5];
      cfg_ie <= pwdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_ctx  <= '0;
    end else if (unwrap_err_pulse) begin
      err_flag <= 1'b1;
      err_ctx  <= err_ctx | unwrap_ctx;
    end else if (force_wr) begin
      err_flag <= 1'b1;
      err_ctx  <= '0;
    end else if (clear_wr) begin
      err_flag <= 1'b0;
      err_ctx  <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      done_seen <= 1'b0;
    else if (cfg_wr && !pwdata[5])
      done_seen <= 1'b0;
    else if (unwrap_done_pulse && cfg_uw)
      done_seen <= 1'b1;
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[31] = cfg_en;
    cfg_word[30] = cfg_kl;
    cfg_word[5]  = cfg_uw;
    cfg_word[0]  = cfg_ie;
    sta_word = '0;
    sta_word[31] = cfg_uw & done_seen;
    sta_word[30] = cfg_uw;
    sta_word[29] = cfg_en;
    sta_word[CTX_LO +: NCTX] = err_ctx;
    sta_word[0]  = err_flag;
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (paddr == CFG_OFS)      prdata = cfg_word;
      else if (paddr == STA_OFS) prdata = sta_word;
    end
  end

  assign engine_en  = cfg_en;
  assign unwrap_en  = cfg_uw;
  assign key_loaded = cfg_kl;
  assign irq        = err_flag & cfg_ie;
endmodule

// File: rtl/fdec_ctrl_regs_chk.sv
module fdec_ctrl_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int NCTX = 4,
  parameter logic [ADDR_W-1:0] CFG_OFS = 12'hC00,
  parameter logic [ADDR_W-1:0] STA_OFS = 12'hC04
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              unwrap_err_pulse,
  input logic [NCTX-1:0]   unwrap_ctx,
  input logic              err_flag,
  input logic [NCTX-1:0]   err_ctx,
  input logic              unwrap_en,
  input logic              cfg_ie,
  input logic              irq
);
  wire force_seen = psel && penable && pwrite && (paddr == CFG_OFS) && pwdata[1];
  wire sta_read   = psel && !pwrite && (paddr == STA_OFS);

  p_detect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    unwrap_err_pulse |=> err_flag && ((err_ctx & $past(unwrap_ctx)) == $past(unwrap_ctx)));

  p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_seen && !unwrap_err_pulse) |=> err_flag && (err_ctx == '0));

  p_ctx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag |-> (err_ctx == '0));

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ie |-> !irq);

  p_done_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_read && !unwrap_en) |-> !prdata[31]);
endmodule

bind fdec_ctrl_regs fdec_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .NCTX(NCTX), .CFG_OFS(CFG_OFS), .STA_OFS(STA_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .unwrap_err_pulse(unwrap_err_pulse), .unwrap_ctx(unwrap_ctx),
  .err_flag(err_flag), .err_ctx(err_ctx), .unwrap_en(unwrap_en),
  .cfg_ie(cfg_ie), .irq(irq)
);

// File: tb/fdec_ctrl_regs_bench.sv
`timescale 1ns/1ps
module fdec_ctrl_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata, rd;
  logic done_p = 0, err_p = 0;
  logic [3:0] ctx = '0;
  logic engine_en, unwrap_en, key_loaded, irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fdec_ctrl_regs u_fdec_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .unwrap_done_pulse(done_p), .unwrap_err_pulse(err_p), .unwrap_ctx(ctx),
    .engine_en(engine_en), .unwrap_en(unwrap_en), .key_loaded(key_loaded), .irq(irq)
  );

  localparam logic [11:0] CFG = 12'hC00, STA = 12'hC04;
  // {write data, expected config readback, expected status readback}
  localparam logic [95:0] VEC [4] = '{
    {32'hFFFF_FFF9, 32'hC000_0021, 32'h6000_0000},
    {32'h8000_0000, 32'h8000_0000, 32'h2000_0000},
    {32'h0000_0020, 32'h0000_0020, 32'h4000_0000},
    {32'h4000_0001, 32'h4000_0001, 32'h0000_0000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic inj = 0, logic [3:0] m = 0);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    if (inj) begin err_p = 1; ctx = m; end
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; err_p = 0; ctx = '0;
  endtask

  task automatic rdreg(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a;
    #1 v = prdata;
    @(negedge clk);
    psel = 0;
  endtask

  task automatic err_pulse(logic [3:0] m);
    @(negedge clk); err_p = 1; ctx = m;
    @(negedge clk); err_p = 0; ctx = '0;
  endtask

  task automatic done_pulse();
    @(negedge clk); done_p = 1;
    @(negedge clk); done_p = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rdreg(CFG, rd); check("R1 cfg reset", rd, 32'h0);
    rdreg(STA, rd); check("R1 sta reset", rd, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    rst_n = 1;

    for (int i = 0; i < 4; i++) begin
      wr(CFG, VEC[i][95:64]);
      rdreg(CFG, rd); check("R2 cfg readback", rd, VEC[i][63:32]);
      rdreg(STA, rd); check("R3 sta mirror", rd, VEC[i][31:0]);
    end

    err_pulse(4'b0101);
    rdreg(STA, rd); check("R4 detect", rd, 32'h0005_0001);
    err_pulse(4'b1000);
    rdreg(STA, rd); check("R4 accumulate", rd, 32'h000D_0001);
    check("R7 irq on", {31'b0, irq}, 32'h1);
    wr(CFG, 32'h4000_0000);
    check("R7 irq masked", {31'b0, irq}, 32'h0);

    wr(STA, 32'h0);
    rdreg(STA, rd); check("R9 status write ignored", rd, 32'h000D_0001);
    rdreg(12'h800, rd); check("R9 unmapped read", rd, 32'h0);

    wr(CFG, 32'h4000_0004);
    rdreg(STA, rd); check("R6 clear", rd, 32'h0);
    rdreg(CFG, rd); check("R6 clear bit reads 0", rd, 32'h4000_0000);

    err_pulse(4'b0010);
    wr(CFG, 32'h0000_0003);
    rdreg(STA, rd); check("R5 force wipes ctx", rd, 32'h0000_0001);
    rdreg(CFG, rd); check("R5 force bit reads 0", rd, 32'h0000_0001);
    check("R7 irq after force", {31'b0, irq}, 32'h1);

    wr(CFG, 32'h0000_0005, 1'b1, 4'b0100);
    rdreg(STA, rd); check("R10 detect beats clear", rd, 32'h0004_0001);
    wr(CFG, 32'h0000_0004);
    rdreg(STA, rd); check("R6 clear again", rd, 32'h0);

    done_pulse();
    wr(CFG, 32'h0000_0020);
    rdreg(STA, rd); check("R8 done ignored while disabled", rd, 32'h4000_0000);
    done_pulse();
    rdreg(STA, rd); check("R8 done set", rd, 32'hC000_0000);
    wr(CFG, 32'h0);
    rdreg(STA, rd); check("R8 done hidden", rd, 32'h0);
    wr(CFG, 32'h0000_0020);
    rdreg(STA, rd); check("R8 done cleared", rd, 32'h4000_0000);

    summary();
  end
endmodule